// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides when a small microcontroller stops its clocks to save power. A pulse on `sleep_req` marks that the CPU has executed its sleep instruction. The standby-select bit in the power control register then picks one of two states. In sleep, only the CPU clock stops. In deep standby, every clock stops and the oscillator enable drops. In deep standby, the serial and analog-converter peripherals are held in reset and every other peripheral keeps its state. A second control bit decides whether the address and bus-control pins float or hold their values while standby lasts.

The block also holds a per-peripheral stop register. A set bit gates that peripheral's clock and masks its interrupt and activation requests. Only writes tagged as coming from the CPU update this register. The two stop bits of the DMA-style engines (bit 15 for the DMA engine, bit 14 for the transfer engine) cannot be set while the matching engine reports that it is busy. Leaving deep standby takes a wake event. The oscillator then restarts and runs for a programmable settling time before any clock is released. Register access is a plain write strobe plus a combinational read port, with no handshake.

Top module: `pdm_ctrl`

## Requirements
- R1: A `sleep_req` pulse in run mode with standby-select (control bit 0) at 1 enters standby on the next edge. In standby, `cpu_clk_en` is 0, `per_clk_en` is all 0, `osc_en` is 0, and `mode` is 2.
- R2: In standby, `per_rst` equals the reset mask (bits 5 and 9 by default, for the serial port and the A/D converter). In every other mode, `per_rst` is 0.
- R3: Bus-hold (control bit 1) at 0 drives `bus_float` to 1 in standby and settling. Bus-hold at 1 keeps `bus_float` at 0. In run and sleep, `bus_float` is 0.
- R4: The stop register sits at address 1. In run mode, `per_clk_en[i]` is the inverse of stop bit i, and `irq_mask` always equals the stop register.
- R5: A CPU write that would set stop bit 15 while `dma_busy` is high, or set stop bit 14 while `xfer_busy` is high, leaves that bit unchanged. The other bits of the same write still apply, and clearing either bit is always allowed.
- R6: A write to the stop register with `reg_src_cpu` at 0 changes nothing.
- R7: A `sleep_req` pulse with standby-select at 0 enters sleep (`mode` 1). In sleep, `cpu_clk_en` is 0, `osc_en` is 1, and peripheral clocks still follow the stop register.
- R8: `wake_evt` in standby moves to settling (`mode` 3) on the next edge, with `osc_en` at 1 and every clock still gated. Settling lasts exactly (F+1)*8 cycles, where F is the settle field in control bits 7:4. Run mode follows.
- R9: `wake_evt` in sleep returns to run mode on the next edge.
- R10: After reset, `mode` is 0 (run), the control register reads 0x00F2, and the stop register reads 0x3FFF. The mode codes are run=0, sleep=1, standby=2, settling=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Write address: 0 selects control, 1 selects module stop |
| reg_wdata | input | 16 | Write data |
| reg_src_cpu | input | 1 | High when the write comes from the CPU |
| reg_raddr | input | 1 | Read address |
| reg_rdata | output | 16 | Read data, combinational |
| sleep_req | input | 1 | One-cycle pulse when the sleep instruction executes |
| wake_evt | input | 1 | Enabled interrupt or external wake event |
| dma_busy | input | 1 | DMA engine active |
| xfer_busy | input | 1 | Transfer engine active |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 16 | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |
| bus_float | output | 1 | Address and bus-control outputs to high impedance |
| per_rst | output | 16 | Per-peripheral standby reset |
| irq_mask | output | 16 | Per-peripheral request mask |
| mode | output | 2 | Current power mode |

## Verification
The mode code is read directly at the ports, so a wrong sequencer state shows on `mode` and on the clock enables one edge after the stimulus that caused it. A faulty settling counter shows as a settling phase of the wrong length, which the bench counts to the exact cycle. A bad stop-register update appears on the read port, on `per_clk_en` and on `irq_mask` at the sample right after the write. A broken busy-engine guard or CPU-source filter therefore shows up after a single write.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_STBY   = 2'd2,
    MODE_SETTLE = 2'd3
  } pd_mode_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STOP = 1'b1;
endpackage

// File: rtl/pdm_regs.sv
module pdm_regs #(
  parameter int NMOD     = 16,
  parameter int SETTLE_W = 4,
  parameter int DMA_BIT  = 15,
  parameter int XFER_BIT = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                waddr,
  input  logic [NMOD-1:0]     wdata,
  input  logic                src_cpu,
  input  logic                raddr,
  output logic [NMOD-1:0]     rdata,
  input  logic                dma_busy,
  input  logic                xfer_busy,
  output logic                stby_sel,
  output logic                bus_hold,
  output logic [SETTLE_W-1:0] settle,
  output logic [NMOD-1:0]     stop
);
  import pdm_pkg::*;

  localparam logic [NMOD-1:0] GUARD_BITS = (NMOD'(1) << DMA_BIT) | (NMOD'(1) << XFER_BIT);
  localparam logic [NMOD-1:0] STOP_RESET = ~GUARD_BITS;

  logic [NMOD-1:0] blocked;
  logic [NMOD-1:0] stop_next;
  logic            wr_ctrl, wr_stop;

  assign wr_ctrl = we && (waddr == ADDR_CTRL);
  assign wr_stop = we && (waddr == ADDR_STOP) && src_cpu;

  // bits that would go from 0 to 1 on a busy engine
  always_comb begin
    blocked = '0;
    blocked[DMA_BIT]  = dma_busy  && wdata[DMA_BIT]  && !stop[DMA_BIT];
    blocked[XFER_BIT] = xfer_busy && wdata[XFER_BIT] && !stop[XFER_BIT];
  end

  genvar g;
  generate
    for (g = 0; g < NMOD; g++) begin : g_stop
      assign stop_next[g] = blocked[g] ? stop[g] : wdata[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_sel <= 1'b0;
      bus_hold <= 1'b1;
      settle   <= '1;
    end else if (wr_ctrl) begin
      stby_sel <= wdata[0];
      bus_hold <= wdata[1];
      settle   <= wdata[4 +: SETTLE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop <= STOP_RESET;
    else if (wr_stop) stop <= stop_next;
  end

  always_comb begin
    rdata = '0;
    if (raddr == ADDR_CTRL) begin
      rdata[0] = stby_sel;
      rdata[1] = bus_hold;
      rdata[4 +: SETTLE_W] = settle;
    end else begin
      rdata = stop;
    end
  end

  p_dma_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == ADDR_STOP && dma_busy && !stop[DMA_BIT]) |=> !stop[DMA_BIT]);
  p_xfer_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == ADDR_STOP && xfer_busy && !stop[XFER_BIT]) |=> !stop[XFER_BIT]);
  p_noncpu_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == ADDR_STOP && !src_cpu) |=> $stable(stop));
endmodule

// File: rtl/pdm_seq.sv
module pdm_seq #(
  parameter int SETTLE_W    = 4,
  parameter int SETTLE_STEP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                wake_evt,
  input  logic                stby_sel,
  input  logic [SETTLE_W-1:0] settle,
  output pdm_pkg::pd_mode_e   state
);
  import pdm_pkg::*;

  localparam int CNT_W = SETTLE_W + $clog2(SETTLE_STEP) + 1;

  pd_mode_e   state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, cnt_load;

  assign cnt_load = (CNT_W'(settle) + CNT_W'(1)) * CNT_W'(SETTLE_STEP) - CNT_W'(1);

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      MODE_RUN: begin
        if (sleep_req) state_nx = stby_sel ? MODE_STBY : MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (wake_evt) state_nx = MODE_RUN;
      end
      MODE_STBY: begin
        if (wake_evt) begin
          state_nx = MODE_SETTLE;
          cnt_nx   = cnt_load;
        end
      end
      MODE_SETTLE: begin
        if (cnt == '0) state_nx = MODE_RUN;
        else cnt_nx = cnt - CNT_W'(1);
      end
      default: state_nx = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MODE_RUN;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  p_sleep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_SLEEP && wake_evt) |=> state == MODE_RUN);
  p_stby_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_STBY && wake_evt) |=> state == MODE_SETTLE);
  p_settle_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_SETTLE) |=> (state == MODE_SETTLE || state == MODE_RUN));
endmodule

// File: rtl/pdm_gate.sv
module pdm_gate #(
  parameter int              NMOD     = 16,
  parameter logic [NMOD-1:0] RST_MASK = 16'h0220
) (
  input  pdm_pkg::pd_mode_e state,
  input  logic              bus_hold,
  input  logic [NMOD-1:0]   stop,
  output logic              cpu_clk_en,
  output logic [NMOD-1:0]   per_clk_en,
  output logic              osc_en,
  output logic              bus_float,
  output logic [NMOD-1:0]   per_rst,
  output logic [NMOD-1:0]   irq_mask
);
  import pdm_pkg::*;

  logic per_run, deep, in_stby;

  assign per_run = (state == MODE_RUN) || (state == MODE_SLEEP);
  assign in_stby = (state == MODE_STBY);
  assign deep    = in_stby || (state == MODE_SETTLE);

  assign cpu_clk_en = (state == MODE_RUN);
  assign osc_en     = !in_stby;
  assign bus_float  = deep && !bus_hold;
  assign irq_mask   = stop;

  genvar g;
  generate
    for (g = 0; g < NMOD; g++) begin : g_per
      assign per_clk_en[g] = per_run && !stop[g];
      assign per_rst[g]    = in_stby && RST_MASK[g];
    end
  endgenerate
endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl #(
  parameter int              NMOD        = 16,
  parameter int              SETTLE_W    = 4,
  parameter int              SETTLE_STEP = 8,
  parameter int              DMA_BIT     = 15,
  parameter int              XFER_BIT    = 14,
  parameter logic [NMOD-1:0] RST_MASK    = 16'h0220
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_addr,
  input  logic [NMOD-1:0] reg_wdata,
  input  logic            reg_src_cpu,
  input  logic            reg_raddr,
  output logic [NMOD-1:0] reg_rdata,
  input  logic            sleep_req,
  input  logic            wake_evt,
  input  logic            dma_busy,
  input  logic            xfer_busy,
  output logic            cpu_clk_en,
  output logic [NMOD-1:0] per_clk_en,
  output logic            osc_en,
  output logic            bus_float,
  output logic [NMOD-1:0] per_rst,
  output logic [NMOD-1:0] irq_mask,
  output logic [1:0]      mode
);
  import pdm_pkg::*;

  logic                stby_sel, bus_hold;
  logic [SETTLE_W-1:0] settle;
  logic [NMOD-1:0]     stop;
  pd_mode_e            state;

  pdm_regs #(.NMOD(NMOD), .SETTLE_W(SETTLE_W), .DMA_BIT(DMA_BIT), .XFER_BIT(XFER_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .src_cpu(reg_src_cpu), .raddr(reg_raddr), .rdata(reg_rdata),
    .dma_busy(dma_busy), .xfer_busy(xfer_busy),
    .stby_sel(stby_sel), .bus_hold(bus_hold), .settle(settle), .stop(stop)
  );

  pdm_seq #(.SETTLE_W(SETTLE_W), .SETTLE_STEP(SETTLE_STEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .stby_sel(stby_sel), .settle(settle), .state(state)
  );

  pdm_gate #(.NMOD(NMOD), .RST_MASK(RST_MASK)) u_gate (
    .state(state), .bus_hold(bus_hold), .stop(stop),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .bus_float(bus_float), .per_rst(per_rst), .irq_mask(irq_mask)
  );

  assign mode = state;

  p_stby_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_RUN && sleep_req && stby_sel) |=> (!cpu_clk_en && !osc_en && per_clk_en == '0));
  p_sleep_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_RUN && sleep_req && !stby_sel) |=> (!cpu_clk_en && osc_en));
  p_settle_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (osc_en && !cpu_clk_en && per_clk_en == '0));
  p_rst_only_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> (per_rst == '0));
endmodule

// File: tb/pdm_ctrl_bench.sv
module pdm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_addr = 1'b0, reg_src_cpu = 1'b1, reg_raddr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sleep_req = 1'b0, wake_evt = 1'b0, dma_busy = 1'b0, xfer_busy = 1'b0;
  logic        cpu_clk_en, osc_en, bus_float;
  logic [15:0] per_clk_en, per_rst, irq_mask;
  logic [1:0]  mode;
  int checks = 0;
  int errors = 0;

  pdm_ctrl u_pdm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_src_cpu(reg_src_cpu), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .dma_busy(dma_busy), .xfer_busy(xfer_busy),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en), .bus_float(bus_float),
    .per_rst(per_rst), .irq_mask(irq_mask), .mode(mode)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input logic cpu);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_src_cpu = cpu;
    step();
    reg_we = 1'b0; reg_src_cpu = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_sleep();
    step();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wake();
    step();
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    chk("R10 mode", mode, 0);
    rd(1'b0, v); chk("R10 ctrl", v, 16'h00F2);
    rd(1'b1, v); chk("R10 stop", v, 16'h3FFF);
    chk("R4 per_clk after reset", per_clk_en, 16'hC000);
    chk("R2 no rst in run", per_rst, 0);
    chk("R3 no float in run", bus_float, 0);
  endtask

  task automatic t_stop_reg();
    logic [15:0] v;
    step();
    wr(1'b1, 16'h00F0, 1'b1);
    rd(1'b1, v); chk("R4 stop readback", v, 16'h00F0);
    chk("R4 per_clk", per_clk_en, 16'hFF0F);
    chk("R4 irq_mask", irq_mask, 16'h00F0);
  endtask

  task automatic t_guard();
    logic [15:0] v;
    dma_busy = 1'b1;
    step();
    wr(1'b1, 16'hC0F0, 1'b1);
    rd(1'b1, v); chk("R5 dma busy blocks bit15", v, 16'h40F0);
    dma_busy = 1'b0; xfer_busy = 1'b1;
    step();
    wr(1'b1, 16'h0000, 1'b1);
    rd(1'b1, v); chk("R5 clear while busy", v, 16'h0000);
    step();
    wr(1'b1, 16'hC000, 1'b1);
    rd(1'b1, v); chk("R5 xfer busy blocks bit14", v, 16'h8000);
    xfer_busy = 1'b0;
    step();
    wr(1'b1, 16'h0000, 1'b1);
  endtask

  task automatic t_noncpu();
    logic [15:0] v;
    step();
    wr(1'b1, 16'h1234, 1'b0);
    rd(1'b1, v); chk("R6 non-cpu write ignored", v, 16'h0000);
    chk("R6 clocks unchanged", per_clk_en, 16'hFFFF);
  endtask

  task automatic t_sleep();
    step();
    wr(1'b0, 16'h0002, 1'b1);
    step();
    wr(1'b1, 16'h0003, 1'b1);
    pulse_sleep();
    chk("R7 mode sleep", mode, 1);
    chk("R7 cpu gated", cpu_clk_en, 0);
    chk("R7 osc on", osc_en, 1);
    chk("R7 per follow stop", per_clk_en, 16'hFFFC);
    chk("R2 no rst in sleep", per_rst, 0);
    repeat (3) @(negedge clk);
    chk("R9 stays asleep", mode, 1);
    pulse_wake();
    chk("R9 back to run", mode, 0);
    chk("R9 cpu clock", cpu_clk_en, 1);
    step();
    wr(1'b1, 16'h0000, 1'b1);
  endtask

  task automatic t_standby(input logic [3:0] f, input logic hold);
    int n;
    step();
    wr(1'b0, {8'h00, f, 2'b00, hold, 1'b1}, 1'b1);
    pulse_sleep();
    chk("R1 mode standby", mode, 2);
    chk("R1 cpu gated", cpu_clk_en, 0);
    chk("R1 per gated", per_clk_en, 0);
    chk("R1 osc off", osc_en, 0);
    chk("R2 standby reset", per_rst, 16'h0220);
    chk("R3 float standby", bus_float, !hold);
    pulse_wake();
    chk("R8 mode settle", mode, 3);
    chk("R8 osc on", osc_en, 1);
    chk("R8 cpu still gated", cpu_clk_en, 0);
    chk("R3 float settle", bus_float, !hold);
    n = 0;
    while (mode == 2'd3 && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk("R8 settle length", n, (f + 1) * 8);
    chk("R8 run after settle", mode, 0);
    chk("R8 cpu on", cpu_clk_en, 1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_stop_reg();
    t_guard();
    t_noncpu();
    t_sleep();
    t_standby(4'd0, 1'b0);
    t_standby(4'd2, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule